// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link for a 2048-byte non-volatile memory. It watches the serial clock, select, data-in and pause pins by oversampling them with a faster system clock. Each transfer starts with an 8-bit command. The block decodes the command, gathers a 16-bit address, and then does one of three things: it streams bytes from the array out on the data-out pin, it hands incoming bytes to a separate page-write controller, or it returns the status byte that the write controller supplies.

The block also holds the write-enable latch, which guards every write. It reads the array through a byte-wide port with a one-cycle read latency. A write is committed only when the select pin is released on a byte boundary. The write controller does the page wrapping, the timing and the cell programming.

Top module: `smc_front`

## Requirements
- R1: Commands are decoded from the first 8 bits of a transfer, sent most significant bit first: 0x03 array read, 0x02 array write, 0x04 clear write enable, 0x06 set write enable, 0x05 status read, 0x01 status write.
- R2: Data-in is sampled on rising serial clock edges, starting with the first rising edge after select goes low. The result is the same whether the clock idles low (mode 0) or high (mode 3).
- R3: Read and write commands take a 16-bit address, sent MSB first. The top 5 bits are ignored and the low 11 bits select the byte.
- R4: Read data is shifted out MSB first and changes on falling clock edges, so the MSB of each byte is valid before the first rising edge of that byte. After each byte the pointer advances by one, and it wraps from 0x7FF to 0x000.
- R5: The output enable is low out of reset, while select is high, and during the command and address phases.
- R6: The write-enable latch is set only when select rises directly after the 8th bit of a 0x06 command. Any further clock rising edge before select rises leaves the latch clear.
- R7: A 0x04 command clears the write-enable latch.
- R8: While the pause input is low, clock and data-in edges are ignored and the output enable is low. After the pause ends, the transfer continues from the bit where it stopped.
- R9: An unrecognized command is ignored, and so is everything after it until select goes high. Nothing is driven out and no write byte is issued.
- R10: While the write controller reports busy, an array read drives nothing out, but a status read still returns the supplied status byte.
- R11: Array and status writes are accepted only while the latch is set and the controller is not busy. Each complete data byte gives a one-cycle strobe with the data and its 11-bit address. The address increments per byte with the same 11-bit wrap. For status writes the address field is 0 and the status flag is set.
- R12: The commit strobe pulses when select rises after at least one complete write byte and with no partial byte pending. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Active-low select pin |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause pin |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for the data-out pad; low means high impedance |
| mem_raddr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data, valid one clock after the address |
| wr_busy | input | 1 | Write controller is in a program cycle |
| status_in | input | 8 | Status byte from the write controller |
| wel | output | 1 | Write-enable latch |
| wr_byte_vld | output | 1 | One-cycle strobe for an accepted write byte |
| wr_to_status | output | 1 | The strobed byte targets the status register |
| wr_addr | output | ADDR_W | Array address of the strobed byte |
| wr_byte | output | 8 | Strobed write data |
| wr_commit | output | 1 | Select rose on a clean byte boundary after write data |

## Verification
The bench uses the default parameters: an 11-bit address, so that the wrap from 0x7FF to 0x000 can be reached in a few bytes, and a 2-stage pin synchronizer. The serial half-period is 8 system clocks, which leaves room for the synchronizer, the edge detector, the one-cycle memory latency and the output register before each sample. With these values every byte path can be exercised in both clock polarities, with the pause entered in the middle of an address byte and in the middle of a data byte.

// File: rtl/smc_pkg.sv
// Shared command codes and state types for the serial memory front end.
package smc_pkg;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'h03;
    localparam logic [7:0] CMD_WR_ARRAY  = 8'h02;
    localparam logic [7:0] CMD_WEN_CLR   = 8'h04;
    localparam logic [7:0] CMD_WEN_SET   = 8'h06;
    localparam logic [7:0] CMD_RD_STATUS = 8'h05;
    localparam logic [7:0] CMD_WR_STATUS = 8'h01;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_RSTAT,
        ST_WDATA,
        ST_WEN_ARM,
        ST_DRAIN
    } smc_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_ARRAY,
        SRC_STATUS
    } smc_src_e;

endpackage

// File: rtl/smc_pin_sync.sv
// Brings the four serial pins into the system clock domain and detects edges.
// Assumes: STAGES >= 2, and each serial clock half-period lasts at least
// STAGES + 4 system clocks.
// Clock edges are reported only while select is active and pause is released.
module smc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_rise,
    output logic si_s,
    output logic hold_s
);
    localparam int NPIN = 4;
    // idle levels: hold_n=1, si=0, cs_n=1, sck=0
    localparam logic [NPIN-1:0] IDLE_LVL = 4'b1010;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] syn;
    logic            sck_q;
    logic            csn_q;

    assign raw = {hold_n, si, cs_n, sck};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        // synchronizer chain for one pin
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{IDLE_LVL[g]}};
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign syn[g] = chain[STAGES-1];
    end

    // remember previous clock and select levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= syn[0];
            csn_q <= syn[1];
        end
    end

    assign cs_act   = ~syn[1];
    assign hold_s   = syn[3];
    assign si_s     = syn[2];
    assign cs_rise  = syn[1] & ~csn_q;
    assign sck_rise = syn[0] & ~sck_q & cs_act & hold_s;
    assign sck_fall = ~syn[0] & sck_q & cs_act & hold_s;

endmodule

// File: rtl/smc_cmd_engine.sv
// Command decoder and sequencer: shifts in the command and address, keeps the
// byte pointer and the write-enable latch, and issues write strobes.
// Assumes: ADDR_W > 8, and the strobes arrive from smc_pin_sync.
module smc_cmd_engine
    import smc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              cs_act,
    input  logic              cs_rise,
    input  logic              si_s,
    input  logic              hold_s,
    input  logic              wr_busy,
    output logic [2:0]        bit_idx,
    output smc_src_e          out_src,
    output logic [ADDR_W-1:0] ptr,
    output logic              wel,
    output logic              wr_byte_vld,
    output logic              wr_to_status,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_byte,
    output logic              wr_commit
);
    localparam int HI_W = ADDR_W - 8;

    smc_state_e      state;
    logic [2:0]      bitcnt;
    logic [6:0]      shreg;
    logic            addr_byte;
    logic            rd_cmd;
    logic            to_status;
    logic            wrote_any;
    logic [HI_W-1:0] ahi;
    logic [7:0]      nb;

    assign nb      = {shreg, si_s};
    assign bit_idx = bitcnt;

    // choose the byte source the output shifter serves
    always_comb begin
        case (state)
            ST_RDATA: out_src = SRC_ARRAY;
            ST_RSTAT: out_src = SRC_STATUS;
            default:  out_src = SRC_NONE;
        endcase
    end

    // command sequencing, latch, pointer and write strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_OPCODE;
            bitcnt       <= 3'd0;
            shreg        <= 7'd0;
            addr_byte    <= 1'b0;
            rd_cmd       <= 1'b0;
            to_status    <= 1'b0;
            wrote_any    <= 1'b0;
            ahi          <= '0;
            ptr          <= '0;
            wel          <= 1'b0;
            wr_byte_vld  <= 1'b0;
            wr_to_status <= 1'b0;
            wr_addr      <= '0;
            wr_byte      <= 8'd0;
            wr_commit    <= 1'b0;
        end else begin
            wr_byte_vld <= 1'b0;
            wr_commit   <= 1'b0;
            if (cs_rise) begin
                if (state == ST_WEN_ARM) wel <= 1'b1;
                if (state == ST_WDATA && bitcnt == 3'd0 && wrote_any) wr_commit <= 1'b1;
            end
            if (!cs_act) begin
                state     <= ST_OPCODE;
                bitcnt    <= 3'd0;
                addr_byte <= 1'b0;
                wrote_any <= 1'b0;
            end else if (sck_rise) begin
                bitcnt <= bitcnt + 3'd1;
                shreg  <= nb[6:0];
                if (state == ST_WEN_ARM) begin
                    state <= ST_DRAIN;
                end else if (bitcnt == 3'd7) begin
                    case (state)
                        ST_OPCODE: begin
                            case (nb)
                                CMD_RD_ARRAY: begin
                                    rd_cmd <= 1'b1;
                                    state  <= ST_ADDR;
                                end
                                CMD_WR_ARRAY: begin
                                    rd_cmd    <= 1'b0;
                                    to_status <= 1'b0;
                                    state     <= (wel && !wr_busy) ? ST_ADDR : ST_DRAIN;
                                end
                                CMD_WEN_CLR: begin
                                    wel   <= 1'b0;
                                    state <= ST_DRAIN;
                                end
                                CMD_WEN_SET:   state <= ST_WEN_ARM;
                                CMD_RD_STATUS: state <= ST_RSTAT;
                                CMD_WR_STATUS: begin
                                    to_status <= 1'b1;
                                    state     <= (wel && !wr_busy) ? ST_WDATA : ST_DRAIN;
                                end
                                default: state <= ST_DRAIN;
                            endcase
                        end
                        ST_ADDR: begin
                            if (!addr_byte) begin
                                addr_byte <= 1'b1;
                                ahi       <= nb[HI_W-1:0];
                            end else begin
                                ptr   <= {ahi, nb};
                                state <= rd_cmd ? (wr_busy ? ST_DRAIN : ST_RDATA) : ST_WDATA;
                            end
                        end
                        ST_RDATA: ptr <= ptr + 1'b1;
                        ST_WDATA: begin
                            wr_byte_vld  <= 1'b1;
                            wr_byte      <= nb;
                            wr_addr      <= to_status ? '0 : ptr;
                            wr_to_status <= to_status;
                            wrote_any    <= 1'b1;
                            if (!to_status) ptr <= ptr + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    p_wr_needs_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte_vld |-> wel);
    p_commit_at_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(cs_rise));
    p_latch_set_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise));
    p_pause_freezes_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && cs_act) |=> $stable(bitcnt));

endmodule

// File: rtl/smc_out_shift.sv
// Output shifter: presents one read bit per falling serial clock edge.
// Assumes: the byte source is stable from the rising edge that ends the
// previous byte until the next falling edge (memory latency of one clock).
module smc_out_shift
    import smc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_fall,
    input  logic     cs_act,
    input  logic     hold_s,
    input  smc_src_e out_src,
    input  logic [2:0] bit_idx,
    input  logic [7:0] mem_rdata,
    input  logic [7:0] status_in,
    output logic     so,
    output logic     so_oe
);
    logic [7:0] cur;
    logic       drive;

    assign cur   = (out_src == SRC_STATUS) ? status_in : mem_rdata;
    assign so_oe = drive && hold_s && cs_act && (out_src != SRC_NONE);

    // update the output bit on each falling edge of a read phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so    <= 1'b0;
            drive <= 1'b0;
        end else if (!cs_act) begin
            drive <= 1'b0;
        end else if (sck_fall && out_src != SRC_NONE) begin
            so    <= cur[~bit_idx];
            drive <= 1'b1;
        end
    end

    p_drive_starts_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(sck_fall));

endmodule

// File: rtl/smc_front.sv
// Top of the serial memory front end: pin synchronizer, command engine and
// output shifter. The data-out pad is expressed as a value plus an enable.
module smc_front
    import smc_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    input  logic              spi_hold_n,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    input  logic              wr_busy,
    input  logic [7:0]        status_in,
    output logic              wel,
    output logic              wr_byte_vld,
    output logic              wr_to_status,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_byte,
    output logic              wr_commit
);
    logic       sck_rise, sck_fall, cs_act, cs_rise, si_s, hold_s;
    logic [2:0] bit_idx;
    smc_src_e   out_src;

    smc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .si       (spi_si),
        .hold_n   (spi_hold_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .cs_rise  (cs_rise),
        .si_s     (si_s),
        .hold_s   (hold_s)
    );

    smc_cmd_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_rise     (sck_rise),
        .cs_act       (cs_act),
        .cs_rise      (cs_rise),
        .si_s         (si_s),
        .hold_s       (hold_s),
        .wr_busy      (wr_busy),
        .bit_idx      (bit_idx),
        .out_src      (out_src),
        .ptr          (mem_raddr),
        .wel          (wel),
        .wr_byte_vld  (wr_byte_vld),
        .wr_to_status (wr_to_status),
        .wr_addr      (wr_addr),
        .wr_byte      (wr_byte),
        .wr_commit    (wr_commit)
    );

    smc_out_shift u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_fall  (sck_fall),
        .cs_act    (cs_act),
        .hold_s    (hold_s),
        .out_src   (out_src),
        .bit_idx   (bit_idx),
        .mem_rdata (mem_rdata),
        .status_in (status_in),
        .so        (spi_so),
        .so_oe     (spi_so_oe)
    );

endmodule

// File: tb/smc_front_tb_top.sv
// Scoreboard bench: transfer tasks push expected bytes into queues,
// a monitor process pops and compares them as the design delivers.
module smc_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        spi_sck, spi_cs_n, spi_si, spi_hold_n;
    logic        spi_so, spi_so_oe;
    logic [10:0] mem_raddr;
    logic [7:0]  mem_rdata;
    logic        wr_busy;
    logic [7:0]  status_in;
    logic        wel, wr_byte_vld, wr_to_status, wr_commit;
    logic [10:0] wr_addr;
    logic [7:0]  wr_byte;

    always #2 clk = ~clk;

    smc_front dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so),
        .spi_so_oe(spi_so_oe), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .wr_busy(wr_busy), .status_in(status_in), .wel(wel),
        .wr_byte_vld(wr_byte_vld), .wr_to_status(wr_to_status),
        .wr_addr(wr_addr), .wr_byte(wr_byte), .wr_commit(wr_commit)
    );

    function automatic logic [7:0] pat(input logic [10:0] a);
        return a[7:0] ^ {a[10:8], a[10:8], 2'b01};
    endfunction

    // array model with one clock of read latency
    always @(posedge clk) mem_rdata <= pat(mem_raddr);

    int checks = 0, fails = 0, n_vld = 0, n_commit = 0;
    bit cpol = 1'b0;
    bit done = 1'b0;
    logic [7:0]  exp_rd[$];
    logic [7:0]  act_rd[$];
    string       tag_rd[$];
    logic [19:0] exp_wr[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare read bytes and write strobes against expectations
    logic [7:0]  m_e, m_a;
    logic [19:0] m_w;
    string       m_t;
    always @(negedge clk) begin
        if (exp_rd.size() > 0 && act_rd.size() > 0) begin
            m_e = exp_rd.pop_front();
            m_a = act_rd.pop_front();
            m_t = tag_rd.pop_front();
            chk(m_a == m_e, m_t, 32'(m_a), 32'(m_e));
        end
        if (wr_byte_vld) begin
            n_vld++;
            if (exp_wr.size() == 0)
                chk(1'b0, "R11 unexpected write strobe", 32'({wr_to_status, wr_addr, wr_byte}), 0);
            else begin
                m_w = exp_wr.pop_front();
                chk(m_w == {wr_to_status, wr_addr, wr_byte}, "R11 write strobe content",
                    32'({wr_to_status, wr_addr, wr_byte}), 32'(m_w));
            end
        end
        if (wr_commit) n_commit++;
    end

    task automatic xbit(input logic b, output logic r, output logic oe);
        spi_sck = 1'b0; spi_si = b; #32;
        r = spi_so; oe = spi_so_oe;
        spi_sck = 1'b1; #32;
    endtask

    task automatic do_hold();
        spi_hold_n = 1'b0; #64;
        for (int i = 0; i < 3; i++) begin
            spi_sck = 1'b0; spi_si = ~spi_si; #32;
            chk(!spi_so_oe, "R8 output released during pause", 32'(spi_so_oe), 0);
            spi_sck = 1'b1; #32;
        end
        spi_hold_n = 1'b1; #64;
    endtask

    task automatic xbyte(input logic [7:0] b, input int hold_at, output logic [7:0] r, output logic oe_any);
        logic o;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) do_hold();
            xbit(b[i], r[i], o);
            oe_any |= o;
        end
    endtask

    task automatic tx_begin();
        spi_sck = cpol; #64; spi_cs_n = 1'b0; #64;
    endtask

    task automatic tx_end();
        spi_sck = cpol; #32; spi_cs_n = 1'b1; #128;
    endtask

    task automatic rd(input logic [15:0] a, input int n, input string tag, input int hold_a, input int hold_d);
        logic [7:0] r; logic o, pre; logic [10:0] ea;
        tx_begin();
        xbyte(8'h03, 8, r, o); pre = o;
        xbyte(a[15:8], hold_a, r, o); pre |= o;
        xbyte(a[7:0], 8, r, o); pre |= o;
        chk(!pre, "R5 output quiet in command and address", 32'(pre), 0);
        ea = a[10:0];
        for (int k = 0; k < n; k++) begin
            exp_rd.push_back(pat(ea)); tag_rd.push_back(tag);
            xbyte(8'h00, (k == 0) ? hold_d : 8, r, o);
            act_rd.push_back(r);
            chk(o, "R4 output driven in data phase", 32'(o), 1);
            ea = ea + 11'd1;
        end
        tx_end();
        chk(!spi_so_oe, "R5 output quiet after select high", 32'(spi_so_oe), 0);
    endtask

    task automatic wr(input logic [7:0] op, input logic [15:0] a, input int nb,
                      input logic [7:0] d0, input int extra, input bit ok, input bit st);
        logic [7:0] r, d; logic o; logic [10:0] ea;
        tx_begin();
        xbyte(op, 8, r, o);
        if (!st) begin
            xbyte(a[15:8], 8, r, o);
            xbyte(a[7:0], 8, r, o);
        end
        ea = a[10:0];
        for (int k = 0; k < nb; k++) begin
            d = d0 + 8'(k * 17);
            if (ok) exp_wr.push_back({st, st ? 11'd0 : ea, d});
            xbyte(d, 8, r, o);
            ea = ea + 11'd1;
        end
        for (int k = 0; k < extra; k++) xbit(1'b1, r, o);
        tx_end();
    endtask

    task automatic cmd_only(input logic [7:0] op);
        logic [7:0] r; logic o;
        tx_begin(); xbyte(op, 8, r, o); tx_end();
    endtask

    initial begin
        logic [7:0] r; logic o, oa; int v0, c0;
        rst_n = 1'b0; wr_busy = 1'b0; status_in = 8'h8D;
        spi_cs_n = 1'b1; spi_sck = 1'b0; spi_si = 1'b0; spi_hold_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(!spi_so_oe, "R5 reset output enable", 32'(spi_so_oe), 0);
        chk(!wel, "R6 reset latch clear", 32'(wel), 0);
        chk(!wr_byte_vld, "R11 reset no strobe", 32'(wr_byte_vld), 0);

        rd(16'h0123, 3, "R1 R2 mode 0 read data", 8, 8);
        rd(16'hF9FE, 2, "R3 upper address bits ignored", 8, 8);
        rd(16'h07FE, 4, "R4 read wraps past top of array", 8, 8);
        cpol = 1'b1;
        rd(16'h0355, 2, "R2 mode 3 read data", 8, 8);
        cpol = 1'b0;
        rd(16'h0040, 2, "R8 read across pauses", 4, 3);

        tx_begin(); xbyte(8'h06, 8, r, o); xbyte(8'h00, 8, r, o); tx_end();
        chk(!wel, "R6 latch clear when clocking continues", 32'(wel), 0);
        cmd_only(8'h06);
        chk(wel, "R6 latch set by clean enable", 32'(wel), 1);
        cmd_only(8'h04);
        chk(!wel, "R7 latch cleared", 32'(wel), 0);

        v0 = n_vld;
        wr(8'h02, 16'h0020, 2, 8'h11, 0, 1'b0, 1'b0);
        chk(n_vld == v0, "R11 write refused with latch clear", 32'(n_vld - v0), 0);

        cmd_only(8'h06);
        c0 = n_commit; v0 = n_vld;
        wr(8'h02, 16'hFFFE, 3, 8'hA5, 0, 1'b1, 1'b0);
        chk(n_vld == v0 + 3, "R11 three write strobes", 32'(n_vld - v0), 3);
        chk(n_commit == c0 + 1, "R12 commit on byte boundary", 32'(n_commit - c0), 1);

        wr(8'h02, 16'h0010, 1, 8'h3C, 3, 1'b1, 1'b0);
        chk(n_commit == c0 + 1, "R12 no commit with partial byte", 32'(n_commit - c0), 1);

        wr(8'h01, 16'h0000, 1, 8'h0C, 0, 1'b1, 1'b1);
        chk(n_commit == c0 + 2, "R12 commit after status write", 32'(n_commit - c0), 2);

        v0 = n_vld;
        tx_begin(); oa = 1'b0;
        xbyte(8'hAB, 8, r, o); oa |= o;
        xbyte(8'h03, 8, r, o); oa |= o;
        xbyte(8'h00, 8, r, o); oa |= o;
        xbyte(8'h10, 8, r, o); oa |= o;
        xbyte(8'h00, 8, r, o); oa |= o;
        tx_end();
        chk(!oa, "R9 unknown command drives nothing", 32'(oa), 0);
        chk(n_vld == v0, "R9 unknown command writes nothing", 32'(n_vld - v0), 0);

        wr_busy = 1'b1;
        tx_begin(); oa = 1'b0;
        xbyte(8'h03, 8, r, o); xbyte(8'h01, 8, r, o); xbyte(8'h00, 8, r, o);
        xbyte(8'h00, 8, r, o); oa |= o;
        xbyte(8'h00, 8, r, o); oa |= o;
        tx_end();
        chk(!oa, "R10 no array data while busy", 32'(oa), 0);
        tx_begin();
        xbyte(8'h05, 8, r, o);
        xbyte(8'h00, 8, r, o);
        chk(r == 8'h8D, "R10 status read while busy", 32'(r), 32'h8D);
        status_in = 8'h42;
        xbyte(8'h00, 8, r, o);
        chk(r == 8'h42, "R10 status read repeats live value", 32'(r), 32'h42);
        tx_end();
        v0 = n_vld;
        wr(8'h02, 16'h0030, 1, 8'h77, 0, 1'b0, 1'b0);
        chk(n_vld == v0, "R11 write refused while busy", 32'(n_vld - v0), 0);
        wr_busy = 1'b0;

        #200;
        chk(exp_rd.size() == 0 && act_rd.size() == 0, "R4 all read bytes compared",
            32'(exp_rd.size() + act_rd.size()), 0);
        chk(exp_wr.size() == 0, "R11 all write strobes seen", 32'(exp_wr.size()), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule